// File: doc/BRIEF.md
# Stepper Driver Fault and Power-Mode Supervisor

This block sits between the control pins and fault detectors of a two-bridge stepper driver and the logic that drives the bridges. It takes three active-low control inputs (output disable, sleep request and translator reset) and a set of synchronised fault flags. From these it produces a per-bridge output enable, an enable for the regulator and charge pump, a request that sends the step translator to its home position, and a permit that tells the translator when step commands may be accepted.

A short-to-ground fault on a bridge is held until the device next leaves sleep. Supply and thermal faults only hold the outputs off while they are present. After every wake-up, and after power-on reset, a settle counter sized from the clock frequency keeps step commands blocked for the charge-pump settle time. The output-disable input gates only the bridges: homing and step permission do not depend on it.

All outputs are registered. An input sampled on one rising clock edge shows on the outputs right after that edge.

Top module: `drv_sup_top`

## Requirements
- R1: While `rst` is high, every `bridge_en` bit, `cp_en`, `step_ok` and every `fault_stat` bit are 0 and `xlat_home` is 1. The settle counter is loaded with its full value.
- R2: `en_n` high clears every `bridge_en` bit after that edge. It has no effect on `xlat_home`, `step_ok`, `cp_en` or the short latches.
- R3: `sleep_n` low clears `cp_en` and every `bridge_en` bit, and sets `xlat_home`, after that edge.
- R4: `step_ok` is 1 only once the settle counter has reached zero and `xlat_home` is 0. The counter is reloaded with WAKE = CLK_HZ/1000*SETTLE_US/1000 while `sleep_n` is low or `rst` is high. It then counts down once per edge at which `sleep_n` is high.
- R5: `stg_flag[b]` sampled high while `sleep_n` is high latches a short on bridge b. `bridge_en[b]` stays 0 after the flag drops. The other bridge is unaffected.
- R6: A short latch clears only on the first edge at which `sleep_n` is sampled high after being low. `reset_n` and `en_n` do not clear it. A flag present on that same edge keeps the latch set.
- R7: `uv_flag`, `ot_flag` and `reg_flag` each clear every `bridge_en` bit only for the edges at which they are sampled high. No state is kept.
- R8: `xlat_home` is 1 after any edge with `uv_flag` or `ot_flag` high, or with any short latch set. `reg_flag` alone does not set it.
- R9: `reset_n` low clears every `bridge_en` bit and sets `xlat_home` for as long as it is held.
- R10: `fault_stat` is registered with this bit order: bits [NB-1:0] are the short latches, bit NB is `reg_flag`, bit NB+1 is `ot_flag`, bit NB+2 is `uv_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on / lockout) |
| en_n | input | 1 | Active-low bridge output enable |
| sleep_n | input | 1 | Active-low sleep request |
| reset_n | input | 1 | Active-low translator reset |
| uv_flag | input | 1 | Undervoltage fault, synchronised |
| ot_flag | input | 1 | Over-temperature fault, synchronised |
| reg_flag | input | 1 | Regulator fault, synchronised |
| stg_flag | input | NB | Per-bridge short-to-ground overcurrent flag |
| bridge_en | output | NB | Per-bridge output enable |
| cp_en | output | 1 | Regulator and charge-pump enable |
| xlat_home | output | 1 | Translator home request |
| step_ok | output | 1 | Step commands may be accepted |
| fault_stat | output | NB+3 | Fault status register |

## Verification
The assertions assume that every input is already synchronous to `clk` and holds steady between rising edges. They also assume the settle count WAKE is at least two, so that a wake edge can never produce a permit on the next edge. The stimulus respects both assumptions: it drives every input one nanosecond after a rising edge and builds the block with a 40-cycle settle window. The sequences cover a short that arrives on the wake edge itself, shorts raised while asleep, and faults that overlap a held translator reset. These cases exercise the latch priority and homing terms together.

// File: rtl/drv_sup_pkg.sv
package drv_sup_pkg;

    // Supply-side fault group, carried as one value through the block
    typedef struct packed {
        logic uv;
        logic ot;
        logic rg;
    } supply_flt_t;

    // Reasons the bridges are held off, apart from the short latches
    typedef struct packed {
        logic disabled;
        logic asleep;
        logic held;
        logic supply;
    } block_why_t;

    // Settle window in clock cycles, floor of one
    function automatic int unsigned settle_cycles(input int unsigned clk_hz,
                                                  input int unsigned us);
        int unsigned n;
        n = (clk_hz / 1000) * us / 1000;
        return (n == 0) ? 1 : n;
    endfunction

    function automatic logic any_supply(input supply_flt_t f);
        return f.uv | f.ot | f.rg;
    endfunction

    function automatic logic homing_supply(input supply_flt_t f);
        return f.uv | f.ot;
    endfunction

endpackage

// File: rtl/drv_sup_short_latch.sv
module drv_sup_short_latch (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic wake_edge,
    input  logic trip,
    output logic held_nxt,
    output logic held
);
    // A trip while armed sets the latch and wins over the clear on a wake edge
    always_comb begin
        held_nxt = (held & ~wake_edge) | (trip & armed);
    end

    always_ff @(posedge clk) begin
        if (rst) held <= 1'b0;
        else     held <= held_nxt;
    end
endmodule

// File: rtl/drv_sup_wake_timer.sv
module drv_sup_wake_timer #(
    parameter int unsigned WAKE = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic awake,
    output logic ready
);
    localparam int unsigned CW = $clog2(WAKE + 1);
    localparam logic [CW-1:0] LOAD = CW'(WAKE);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || !awake)       remain <= LOAD;
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign ready = (remain == '0);
endmodule

// File: rtl/drv_sup_out_stage.sv
module drv_sup_out_stage
    import drv_sup_pkg::*;
#(
    parameter int unsigned NB = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  block_why_t      why,
    input  supply_flt_t     sup,
    input  logic            awake,
    input  logic            xl_reset,
    input  logic [NB-1:0]   short_nxt,
    output logic [NB-1:0]   bridge_en,
    output logic            cp_en,
    output logic            home,
    output logic [NB+2:0]   stat
);
    logic common_ok;
    logic home_nxt;

    assign common_ok = ~(why.disabled | why.asleep | why.held | why.supply);
    assign home_nxt  = ~awake | xl_reset | homing_supply(sup) | (|short_nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            cp_en <= 1'b0;
            home  <= 1'b1;
            stat  <= '0;
        end else begin
            cp_en <= awake;
            home  <= home_nxt;
            stat  <= {sup.uv, sup.ot, sup.rg, short_nxt};
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst) bridge_en[b] <= 1'b0;
            else     bridge_en[b] <= common_ok & ~short_nxt[b];
        end
    end
endmodule

// File: rtl/drv_sup_top.sv
module drv_sup_top
    import drv_sup_pkg::*;
#(
    parameter int unsigned NB        = 2,
    parameter int unsigned CLK_HZ    = 200_000_000,
    parameter int unsigned SETTLE_US = 1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_n,
    input  logic            sleep_n,
    input  logic            reset_n,
    input  logic            uv_flag,
    input  logic            ot_flag,
    input  logic            reg_flag,
    input  logic [NB-1:0]   stg_flag,
    output logic [NB-1:0]   bridge_en,
    output logic            cp_en,
    output logic            xlat_home,
    output logic            step_ok,
    output logic [NB+2:0]   fault_stat
);
    localparam int unsigned WAKE = settle_cycles(CLK_HZ, SETTLE_US);

    logic        sleep_q;
    logic        wake_edge;
    logic        timer_ready;
    logic [NB-1:0] short_nxt;
    logic [NB-1:0] short_q;
    supply_flt_t sup;
    block_why_t  why;

    // Previous sleep input; cleared by reset so power-up counts as a wake
    always_ff @(posedge clk) begin
        if (rst) sleep_q <= 1'b0;
        else     sleep_q <= sleep_n;
    end

    assign wake_edge = sleep_n & ~sleep_q;

    assign sup.uv = uv_flag;
    assign sup.ot = ot_flag;
    assign sup.rg = reg_flag;

    assign why.disabled = en_n;
    assign why.asleep   = ~sleep_n;
    assign why.held     = ~reset_n;
    assign why.supply   = any_supply(sup);

    for (genvar b = 0; b < NB; b++) begin : g_short
        drv_sup_short_latch u_latch (
            .clk      (clk),
            .rst      (rst),
            .armed    (sleep_n),
            .wake_edge(wake_edge),
            .trip     (stg_flag[b]),
            .held_nxt (short_nxt[b]),
            .held     (short_q[b])
        );
    end

    drv_sup_wake_timer #(.WAKE(WAKE)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .awake(sleep_n),
        .ready(timer_ready)
    );

    drv_sup_out_stage #(.NB(NB)) u_out (
        .clk      (clk),
        .rst      (rst),
        .why      (why),
        .sup      (sup),
        .awake    (sleep_n),
        .xl_reset (~reset_n),
        .short_nxt(short_nxt),
        .bridge_en(bridge_en),
        .cp_en    (cp_en),
        .home     (xlat_home),
        .stat     (fault_stat)
    );

    assign step_ok = timer_ready & ~xlat_home;
endmodule

// File: rtl/drv_sup_chk.sv
module drv_sup_chk #(
    parameter int unsigned NB = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          en_n,
    input logic          sleep_n,
    input logic          reset_n,
    input logic          uv_flag,
    input logic          ot_flag,
    input logic          reg_flag,
    input logic [NB-1:0] stg_flag,
    input logic [NB-1:0] bridge_en,
    input logic          cp_en,
    input logic          xlat_home,
    input logic          step_ok,
    input logic [NB+2:0] fault_stat
);
    assert_disable_off_R2: assert property (@(posedge clk) disable iff (rst)
        en_n |=> (bridge_en == '0));

    assert_sleep_off_R3: assert property (@(posedge clk) disable iff (rst)
        !sleep_n |=> (!cp_en && xlat_home && bridge_en == '0));

    assert_wake_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_n) |=> !step_ok);

    assert_permit_needs_pump_R4: assert property (@(posedge clk) disable iff (rst)
        step_ok |-> (cp_en && !xlat_home));

    assert_fault_off_R7: assert property (@(posedge clk) disable iff (rst)
        (uv_flag || ot_flag || reg_flag) |=> (bridge_en == '0));

    assert_home_fault_R8: assert property (@(posedge clk) disable iff (rst)
        (uv_flag || ot_flag) |=> xlat_home);

    assert_xlat_reset_R9: assert property (@(posedge clk) disable iff (rst)
        !reset_n |=> (xlat_home && bridge_en == '0));

    for (genvar b = 0; b < NB; b++) begin : g_b
        assert_short_trip_R5: assert property (@(posedge clk) disable iff (rst)
            (stg_flag[b] && sleep_n) |=> (!bridge_en[b] && fault_stat[b]));

        assert_short_hold_R6: assert property (@(posedge clk) disable iff (rst)
            ($fell(stg_flag[b]) && sleep_n && $past(sleep_n)) |=> !bridge_en[b]);
    end
endmodule

bind drv_sup_top drv_sup_chk #(.NB(NB)) chk_i (.*);

// File: tb/drv_sup_top_tb_top.sv
`timescale 1ns/100ps
module drv_sup_top_tb_top;
    localparam int NB = 2;
    localparam int CLK_HZ = 20_000_000;
    localparam int SETTLE_US = 2;
    localparam int WAKE = CLK_HZ / 1000 * SETTLE_US / 1000;

    logic clk = 0;
    logic rst = 1;
    logic en_n = 0, sleep_n = 1, reset_n = 1;
    logic uv_flag = 0, ot_flag = 0, reg_flag = 0;
    logic [NB-1:0] stg_flag = '0;
    logic [NB-1:0] bridge_en;
    logic cp_en, xlat_home, step_ok;
    logic [NB+2:0] fault_stat;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit live = 0;

    // reference state
    logic [NB-1:0] m_lat = '0;
    bit m_prev_sleep = 0;
    int m_cnt = WAKE;
    logic [NB-1:0] m_en = '0;
    bit m_cp = 0, m_home = 1, m_step = 0, m_rst = 1;
    logic [NB+2:0] m_stat = '0;

    always #2.5 clk = ~clk;

    drv_sup_top #(.NB(NB), .CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US)) dut_i (
        .clk(clk), .rst(rst), .en_n(en_n), .sleep_n(sleep_n), .reset_n(reset_n),
        .uv_flag(uv_flag), .ot_flag(ot_flag), .reg_flag(reg_flag), .stg_flag(stg_flag),
        .bridge_en(bridge_en), .cp_en(cp_en), .xlat_home(xlat_home),
        .step_ok(step_ok), .fault_stat(fault_stat)
    );

    always @(posedge clk) begin
        bit wake;
        bit ok;
        wake = sleep_n && !m_prev_sleep;
        for (int b = 0; b < NB; b++)
            m_lat[b] = rst ? 1'b0 : ((m_lat[b] && !wake) || (stg_flag[b] && sleep_n));
        m_prev_sleep = rst ? 1'b0 : sleep_n;
        ok = !en_n && sleep_n && reset_n && !uv_flag && !ot_flag && !reg_flag;
        for (int b = 0; b < NB; b++) m_en[b] = !rst && ok && !m_lat[b];
        m_cp = !rst && sleep_n;
        m_home = rst || !reset_n || !sleep_n || uv_flag || ot_flag || (m_lat != 0);
        if (rst || !sleep_n) m_cnt = WAKE;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        m_step = (m_cnt == 0) && !m_home;
        m_stat = rst ? '0 : {uv_flag, ot_flag, reg_flag, m_lat};
        m_rst = rst;
        live = 1;
        cycles++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (live) begin
            if (m_rst) begin
                chk("R1 bridge_en", 32'(bridge_en), 32'(m_en));
                chk("R1 home", 32'(xlat_home), 32'(m_home));
                chk("R1 step", 32'(step_ok), 32'(m_step));
            end else begin
                chk("R2 R3 R5 R6 R7 R9 bridge_en", 32'(bridge_en), 32'(m_en));
                chk("R3 cp_en", 32'(cp_en), 32'(m_cp));
                chk("R8 R9 R3 xlat_home", 32'(xlat_home), 32'(m_home));
                chk("R4 step_ok", 32'(step_ok), 32'(m_step));
                chk("R10 fault_stat", 32'(fault_stat), 32'(m_stat));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // watchdog
    initial begin
        #(5ns * 100000);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        tick(3);
        rst = 0;
        // R4: settle window after power-on
        tick(WAKE + 4);
        // R2: output disable leaves homing and permit alone
        en_n = 1; tick(3); en_n = 0; tick(2);
        // R5: short on bridge 0, then flag drops
        stg_flag = 2'b01; tick(2); stg_flag = 0; tick(4);
        // R6: reset_n and en_n do not clear; R9 held reset
        reset_n = 0; tick(3); reset_n = 1; tick(2);
        en_n = 1; tick(1); en_n = 0; tick(2);
        // R3 + R6: sleep exit clears latch
        sleep_n = 0; tick(4);
        stg_flag = 2'b10; tick(2); stg_flag = 0;  // ignored while asleep
        sleep_n = 1; tick(WAKE + 3);
        // R6: short present on wake edge keeps latch
        sleep_n = 0; tick(3);
        sleep_n = 1; stg_flag = 2'b10; tick(1); stg_flag = 0; tick(5);
        sleep_n = 0; tick(2); sleep_n = 1; tick(WAKE + 3);
        // R7 / R8: supply faults
        uv_flag = 1; tick(2); uv_flag = 0; tick(2);
        ot_flag = 1; tick(3); ot_flag = 0; tick(2);
        reg_flag = 1; tick(3); reg_flag = 0; tick(2);
        // overlap of faults with held reset
        reset_n = 0; ot_flag = 1; stg_flag = 2'b11; tick(2);
        ot_flag = 0; stg_flag = 0; tick(2); reset_n = 1; tick(3);
        // mid-window sleep re-entry
        sleep_n = 0; tick(2); sleep_n = 1; tick(WAKE / 2);
        sleep_n = 0; tick(1); sleep_n = 1; tick(WAKE + 3);
        // R1: reset again mid-run
        rst = 1; tick(3); rst = 0; tick(WAKE + 3);
        finish_run();
    end
endmodule